// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple request port and an asynchronous DRAM that takes its address in two halves over one shared bus. Each request carries a full word address, a read/write flag and write data. The controller splits the address into a row part (upper bits) and a column part (lower bits). It strobes the row in with an active-low row strobe and the column with an active-low column strobe. The read data comes back on a one-cycle response pulse.

The row stays open after an access. The open row acts as a single-entry row cache. A later request to the same row is a hit and costs only a column cycle. A request to any other row is a miss. On a miss the controller raises the row strobe to precharge, keeps it high for the precharge minimum, and then opens the new row. The open row is also closed after a programmable number of idle cycles.

Four cycle-count minimums are enforced: row strobe high before a new row opens, row strobe low before data capture, column strobe low before data capture, and column-strobe fall to the next column-strobe fall within a page. Every response reports whether the request hit the open row.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset the row strobe, column strobe and write enable are high, the data drive enable is low, no response is pending, the request port is ready, and no row counts as open, so the first access reports a miss.
- R2: The row is the upper ROW_W bits of the request address and the column is the lower COL_W bits. The row is on the bus when the row strobe falls, and the column is on the bus when the column strobe falls.
- R3: A request whose row is not open raises the row strobe (if it is low), keeps it high for at least T_PRE cycles, and then drops it with the new row. Its response reports rsp_hit = 0.
- R4: A request to the open row causes no row strobe transition. It performs only a column cycle and reports rsp_hit = 1. Reads and writes may be mixed freely within one open row.
- R5: Read data is captured only after the column strobe has been low for at least T_COL cycles and the row strobe has been low for at least T_ROW cycles.
- R6: Two consecutive falling edges of the column strobe are at least T_CYC cycles apart.
- R7: For a write, write enable is low and the data drive is enabled with the write data from at least one cycle before the column strobe falls until it rises, with no change in between. A read keeps write enable high and the drive disabled.
- R8: Each accepted request produces exactly one single-cycle rsp_valid pulse. For a read, rsp_rdata holds the data stored at the addressed location.
- R9: After T_IDLE consecutive idle cycles with a row open, the row strobe rises. The next access to that row then reports a miss.
- R10: req_ready is high only when the controller is idle. A request is taken in the cycle where req_valid and req_ready are both high.
- R11: The column strobe is low only while the row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Request hit the open row |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Data driven to the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The embedded properties assume only that reset starts the controller cleanly. They assume nothing about request timing, because the controller holds off new requests by lowering req_ready. The one input with a timing dependency is dram_dq_in: it must be valid at the capture edge. The bench memory model therefore returns the inverted stored value whenever the column-low or row-low minimum has not yet elapsed, so a capture that comes too early is seen as wrong data. The model also measures strobe widths, gaps and write setup from the pins at falling clock edges. The bench holds req_valid for one cycle only, while req_ready is high.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRECH = 3'd1,
        ST_ROW   = 3'd2,
        ST_SETUP = 3'd3,
        ST_COL   = 3'd4
    } fpm_state_e;
endpackage

// File: rtl/fpm_addr_split.sv
module fpm_addr_split #(
    parameter int ROW_W = 11,
    parameter int COL_W = 11
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col
);
    // row in the upper bits, column in the lower bits
    assign row = addr[ROW_W+COL_W-1:COL_W];
    assign col = addr[COL_W-1:0];
endmodule

// File: rtl/fpm_span_timer.sv
// Counts how many cycles a level has lasted. FALL_ONLY=1 restarts only on a
// 1->0 transition, which gives the time since the last falling edge.
module fpm_span_timer #(
    parameter int   CNT_W     = 4,
    parameter bit   FALL_ONLY = 1'b0,
    parameter logic RST_LVL   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_d,
    output logic [CNT_W-1:0] span
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             lvl_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             restart;

    generate
        if (FALL_ONLY) begin : g_fall
            assign restart = lvl_q & ~lvl_d;
        end else begin : g_any
            assign restart = lvl_q ^ lvl_d;
        end
    endgenerate

    always_comb begin
        if (restart)
            cnt_d = '0;
        else if (cnt_q == CNT_MAX)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    assign span = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= RST_LVL;
            cnt_q <= '0;
        end else begin
            lvl_q <= lvl_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W  = 11,
    parameter int COL_W  = 11,
    parameter int DATA_W = 1,
    parameter int T_PRE  = 3,
    parameter int T_ROW  = 5,
    parameter int T_COL  = 2,
    parameter int T_CYC  = 3,
    parameter int T_IDLE = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ROW_W+COL_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic                    dram_ras_n,
    output logic                    dram_cas_n,
    output logic                    dram_we_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic [DATA_W-1:0]       dram_dq_out,
    output logic                    dram_dq_oe,
    input  logic [DATA_W-1:0]       dram_dq_in
);
    localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int TM1   = (T_PRE > T_ROW) ? T_PRE : T_ROW;
    localparam int TM2   = (T_COL > T_CYC) ? T_COL : T_CYC;
    localparam int TM3   = (TM1 > TM2) ? TM1 : TM2;
    localparam int TMAX  = (TM3 > T_IDLE) ? TM3 : T_IDLE;
    localparam int CNT_W = $clog2(TMAX + 1) + 1;

    localparam logic [CNT_W-1:0] PRE_C  = CNT_W'(T_PRE);
    localparam logic [CNT_W-1:0] ROW_C  = CNT_W'(T_ROW);
    localparam logic [CNT_W-1:0] COL_C  = CNT_W'(T_COL);
    localparam logic [CNT_W-1:0] CYC_C  = CNT_W'(T_CYC);
    localparam logic [CNT_W-1:0] IDLE_C = CNT_W'(T_IDLE);

    typedef struct packed {
        fpm_state_e        state;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe;
        logic [BUS_W-1:0]  bus;
        logic [DATA_W-1:0] dq;
        logic              open;
        logic [ROW_W-1:0]  open_row;
        logic              p_write;
        logic [COL_W-1:0]  p_col;
        logic [ROW_W-1:0]  p_row;
        logic [DATA_W-1:0] p_wdata;
        logic              p_hit;
        logic              rsp_valid;
        logic              rsp_hit;
        logic [DATA_W-1:0] rsp_rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ROW_W-1:0] in_row;
    logic [COL_W-1:0] in_col;
    logic [CNT_W-1:0] ras_span, cas_span, gap_span, idle_span;

    fpm_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr (req_addr),
        .row  (in_row),
        .col  (in_col)
    );

    fpm_span_timer #(.CNT_W(CNT_W), .FALL_ONLY(1'b0), .RST_LVL(1'b1)) u_ras_tmr (
        .clk(clk), .rst_n(rst_n), .lvl_d(ctl_d.ras_n), .span(ras_span)
    );

    fpm_span_timer #(.CNT_W(CNT_W), .FALL_ONLY(1'b0), .RST_LVL(1'b1)) u_cas_tmr (
        .clk(clk), .rst_n(rst_n), .lvl_d(ctl_d.cas_n), .span(cas_span)
    );

    fpm_span_timer #(.CNT_W(CNT_W), .FALL_ONLY(1'b1), .RST_LVL(1'b1)) u_gap_tmr (
        .clk(clk), .rst_n(rst_n), .lvl_d(ctl_d.cas_n), .span(gap_span)
    );

    fpm_span_timer #(.CNT_W(CNT_W), .FALL_ONLY(1'b0), .RST_LVL(1'b0)) u_idle_tmr (
        .clk(clk), .rst_n(rst_n),
        .lvl_d(ctl_d.state == ST_IDLE && ctl_d.open), .span(idle_span)
    );

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.p_write = req_write;
                    ctl_d.p_row   = in_row;
                    ctl_d.p_col   = in_col;
                    ctl_d.p_wdata = req_wdata;
                    ctl_d.p_hit   = ctl_q.open && (in_row == ctl_q.open_row);
                    if (ctl_q.open && (in_row == ctl_q.open_row)) begin
                        ctl_d.state = ST_SETUP;
                        ctl_d.bus   = BUS_W'(in_col);
                        ctl_d.we_n  = ~req_write;
                        ctl_d.oe    = req_write;
                        ctl_d.dq    = req_write ? req_wdata : '0;
                    end else begin
                        ctl_d.state = ST_PRECH;
                        ctl_d.ras_n = 1'b1;
                        ctl_d.open  = 1'b0;
                        ctl_d.bus   = BUS_W'(in_row);
                    end
                end else if (ctl_q.open && idle_span >= IDLE_C) begin
                    ctl_d.ras_n = 1'b1;
                    ctl_d.open  = 1'b0;
                end
            end
            ST_PRECH: begin
                if (ras_span >= PRE_C) begin
                    ctl_d.ras_n    = 1'b0;
                    ctl_d.open     = 1'b1;
                    ctl_d.open_row = ctl_q.p_row;
                    ctl_d.state    = ST_ROW;
                end
            end
            ST_ROW: begin
                ctl_d.state = ST_SETUP;
                ctl_d.bus   = BUS_W'(ctl_q.p_col);
                ctl_d.we_n  = ~ctl_q.p_write;
                ctl_d.oe    = ctl_q.p_write;
                ctl_d.dq    = ctl_q.p_write ? ctl_q.p_wdata : '0;
            end
            ST_SETUP: begin
                if (gap_span >= CYC_C) begin
                    ctl_d.cas_n = 1'b0;
                    ctl_d.state = ST_COL;
                end
            end
            ST_COL: begin
                if (cas_span >= COL_C && ras_span >= ROW_C) begin
                    ctl_d.cas_n     = 1'b1;
                    ctl_d.we_n      = 1'b1;
                    ctl_d.oe        = 1'b0;
                    ctl_d.state     = ST_IDLE;
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_hit   = ctl_q.p_hit;
                    ctl_d.rsp_rdata = ctl_q.p_write ? '0 : dram_dq_in;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.ras_n <= 1'b1;
            ctl_q.cas_n <= 1'b1;
            ctl_q.we_n  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready   = (ctl_q.state == ST_IDLE);
    assign rsp_valid   = ctl_q.rsp_valid;
    assign rsp_hit     = ctl_q.rsp_hit;
    assign rsp_rdata   = ctl_q.rsp_rdata;
    assign dram_ras_n  = ctl_q.ras_n;
    assign dram_cas_n  = ctl_q.cas_n;
    assign dram_we_n   = ctl_q.we_n;
    assign dram_addr   = ctl_q.bus;
    assign dram_dq_out = ctl_q.dq;
    assign dram_dq_oe  = ctl_q.oe;

    // R11
    cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R3
    precharge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $past(ras_span) >= PRE_C);

    // R5
    capture_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(cas_span) >= COL_C) && ($past(ras_span) >= ROW_C));

    // R6
    page_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $past(gap_span) >= CYC_C);

    // R7
    write_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> $stable(dram_we_n) && $stable(dram_dq_oe) && $stable(dram_dq_out));

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> dram_cas_n);
endmodule

// File: tb/fpm_dram_ctrl_test.sv
module fpm_dram_ctrl_test;
    localparam int ROW_W = 4, COL_W = 4, DATA_W = 4;
    localparam int T_PRE = 3, T_ROW = 5, T_COL = 2, T_CYC = 4, T_IDLE = 20;
    localparam int AW = ROW_W + COL_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_hit;
    logic [DATA_W-1:0] rsp_rdata;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [3:0] dram_addr;
    logic [DATA_W-1:0] dram_dq_out;
    logic [DATA_W-1:0] dram_dq_in = '0;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    fpm_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_PRE(T_PRE),
        .T_ROW(T_ROW), .T_COL(T_COL), .T_CYC(T_CYC), .T_IDLE(T_IDLE)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // memory model, observed at falling clock edges
    logic [DATA_W-1:0] mem    [256];
    logic [DATA_W-1:0] shadow [256];
    int m_ras_hi = 1000, m_ras_lo = 0, m_cas_lo = 0, m_gap = 1000, ras_falls = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
    logic [3:0] row_lat = '0, col_lat = '0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = '0;
            shadow[i] = '0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (dram_ras_n) begin
                m_ras_hi = prev_ras ? m_ras_hi + 1 : 1;
                m_ras_lo = 0;
            end else if (prev_ras) begin
                chk(m_ras_hi >= T_PRE, "R3 precharge width", m_ras_hi, T_PRE);
                row_lat = dram_addr;
                ras_falls++;
                m_ras_lo = 1;
            end else begin
                m_ras_lo++;
            end
            m_gap++;
            if (!dram_cas_n) begin
                if (prev_cas) begin
                    chk(!dram_ras_n, "R11 column strobe under row strobe", dram_ras_n, 0);
                    chk(m_gap >= T_CYC, "R6 column fall gap", m_gap, T_CYC);
                    m_gap = 0;
                    col_lat = dram_addr;
                    if (!dram_we_n) begin
                        chk(dram_dq_oe, "R7 drive enabled on write", dram_dq_oe, 1);
                        chk(!prev_we, "R7 write enable setup", prev_we, 0);
                        mem[{row_lat, col_lat}] = dram_dq_out;
                    end else begin
                        chk(!dram_dq_oe, "R7 drive off on read", dram_dq_oe, 0);
                    end
                    m_cas_lo = 1;
                end else begin
                    m_cas_lo++;
                    chk(dram_we_n == prev_we, "R7 write enable stable", dram_we_n, prev_we);
                end
            end else begin
                m_cas_lo = 0;
            end
            if (!dram_cas_n && dram_we_n && m_cas_lo >= T_COL && m_ras_lo >= T_ROW)
                dram_dq_in = mem[{row_lat, col_lat}];
            else
                dram_dq_in = ~mem[{row_lat, col_lat}];
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
            prev_we  = dram_we_n;
        end
    end

    task automatic do_req(input bit wr, input logic [3:0] row, input logic [3:0] col,
                          input logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] rd,
                          output bit hit);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = {row, col}; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R10 ready low while busy", req_ready, 0);
        while (!rsp_valid) @(negedge clk);
        rd = rsp_rdata;
        hit = rsp_hit;
        if (wr) shadow[{row, col}] = wd;
        @(negedge clk);
        chk(!rsp_valid, "R8 single response pulse", rsp_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes high", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        chk(!dram_dq_oe && !rsp_valid, "R1 drive and response idle", {dram_dq_oe, rsp_valid}, 0);
        chk(req_ready, "R1 ready after reset", req_ready, 1);
    endtask

    task automatic t_page_mixed();
        logic [DATA_W-1:0] rd;
        bit hit;
        int f0 = ras_falls;
        for (int c = 0; c < 4; c++) begin
            do_req(1'b1, 4'd3, 4'(c), 4'(c + 5), rd, hit);
            if (c == 0) chk(!hit, "R1 R3 first access misses", hit, 0);
            else        chk(hit, "R4 write hit in open row", hit, 1);
        end
        chk(row_lat == 4'd3 && col_lat == 4'd3, "R2 row and column split", {row_lat, col_lat}, 8'h33);
        for (int c = 0; c < 4; c++) begin
            do_req(1'b0, 4'd3, 4'(c), '0, rd, hit);
            chk(rd == shadow[{4'd3, 4'(c)}], "R5 R8 read data", rd, shadow[{4'd3, 4'(c)}]);
            chk(hit, "R4 read hit in open row", hit, 1);
        end
        do_req(1'b1, 4'd3, 4'd9, 4'hA, rd, hit);
        chk(hit, "R4 write after reads hits", hit, 1);
        chk(ras_falls - f0 == 1, "R4 one row open for whole page", ras_falls - f0, 1);
        chk(mem[8'h39] == 4'hA, "R7 write reached memory", mem[8'h39], 10);
    endtask

    task automatic t_row_switch();
        logic [DATA_W-1:0] rd;
        bit hit;
        int f0 = ras_falls;
        do_req(1'b1, 4'd9, 4'd2, 4'hC, rd, hit);
        chk(!hit, "R3 new row misses", hit, 0);
        chk(row_lat == 4'd9 && col_lat == 4'd2, "R2 new row latched", {row_lat, col_lat}, 8'h92);
        do_req(1'b0, 4'd3, 4'd1, '0, rd, hit);
        chk(!hit, "R3 return row misses", hit, 0);
        chk(rd == 4'd6, "R8 data kept across rows", rd, 6);
        chk(ras_falls - f0 == 2, "R3 row strobe per miss", ras_falls - f0, 2);
        do_req(1'b0, 4'd12, 4'd7, '0, rd, hit);
        chk(rd == 4'd0, "R5 R8 unwritten location", rd, 0);
    endtask

    task automatic t_idle_close();
        logic [DATA_W-1:0] rd;
        bit hit;
        do_req(1'b0, 4'd5, 4'd5, '0, rd, hit);
        repeat (T_IDLE - 4) @(negedge clk);
        chk(!dram_ras_n, "R9 row still open before timeout", dram_ras_n, 0);
        repeat (8) @(negedge clk);
        chk(dram_ras_n, "R9 row closed after idle", dram_ras_n, 1);
        do_req(1'b0, 4'd5, 4'd5, '0, rd, hit);
        chk(!hit, "R9 access after close misses", hit, 0);
        do_req(1'b0, 4'd5, 4'd6, '0, rd, hit);
        chk(hit, "R4 reopened row hits", hit, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: no response actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_page_mixed();
        t_row_switch();
        t_idle_close();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule